// File: doc/BRIEF.md
# LCD horizontal line timing generator

This block produces the horizontal timing of a display line. Every line is walked through four phases in a fixed order: the active phase, in which pixel data is presented, a front porch of dummy pixel clocks, a line-clock pulse (horizontal sync), and a back porch of dummy pixel clocks before the next line's pixels begin. The block advances only on cycles where the pixel clock enable is high. A downstream vertical counter consumes its one-cycle end-of-line pulse.

Four configuration fields set the phase lengths. Each holds the wanted count minus one, so a field of zero still gives one pixel clock. A mode input picks passive or active panel behaviour: for a passive panel the outgoing pixel clock enable is held off outside the active phase, and for an active panel it follows the input enable through every phase. The polarity of the sync output can be chosen. Field values are captured only when a phase begins, so software may rewrite them at any time without disturbing the phase under way.

Top module: `lcd_hline_gen`

## Requirements
- R1: While `rst` is high the block sits at the start of the back porch: `pix_valid` is 0, `line_sync` equals `!sync_pol` (negated), and after `rst` falls the back porch lasts `cfg_back`+1 enabled cycles.
- R2: Phases follow the order active, front porch, sync, back porch, then active again; only enabled cycles (`pix_en`=1) count toward a phase.
- R3: The sync phase lasts `cfg_sync`+1 enabled cycles, a 6-bit field giving 1 to 64.
- R4: The front porch lasts `cfg_front`+1 enabled cycles, an 8-bit field giving 1 to 256.
- R5: The back porch lasts `cfg_back`+1 enabled cycles, an 8-bit field giving 1 to 256.
- R6: The active phase lasts `cfg_ppl`+1 enabled cycles, and `pix_valid` is 1 exactly during that phase.
- R7: With `passive_mode`=1, `pix_clk_en` equals `pix_en` during the active phase and is 0 during front porch, sync and back porch.
- R8: With `passive_mode`=0, `pix_clk_en` equals `pix_en` in every phase.
- R9: `line_sync` equals `sync_pol` during the sync phase and `!sync_pol` in every other phase.
- R10: `line_end` is 1 only in the single enabled cycle that completes the back porch, and the active phase begins right after it.
- R11: A field is captured when its phase begins; a change to any field during a phase leaves that phase's length unchanged and takes effect the next time that phase begins.
- R12: In a cycle with `pix_en`=0 the phase and its remaining length hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel clock enable, one pixel period per high cycle |
| passive_mode | input | 1 | 1 = passive panel (pixel clock gated outside active phase), 0 = active panel |
| sync_pol | input | 1 | Level of `line_sync` while the sync pulse is asserted |
| cfg_sync | input | 6 | Sync pulse width minus one |
| cfg_front | input | 8 | Front porch length minus one |
| cfg_back | input | 8 | Back porch length minus one |
| cfg_ppl | input | PPL_W (11) | Pixels per line minus one |
| line_sync | output | 1 | Line clock / horizontal sync |
| pix_valid | output | 1 | High during the active phase |
| pix_clk_en | output | 1 | Pixel clock enable forwarded to the panel |
| line_end | output | 1 | One enabled cycle pulse when the back porch ends |

## Verification
The hardest situation to reach is a field rewrite that lands in the middle of a phase, combined with enable gaps, since only that shows whether a length is latched at phase entry or read live. The stimulus rewrites fields at random cycles while `pix_en` toggles randomly, and the bench model latches each field only when it enters the matching phase, so any live read shows up as a phase boundary at the wrong cycle. Directed runs add the all-zero fields (four-cycle lines) and the largest sync and porch values.

// File: rtl/lhtg_pkg.sv
package lhtg_pkg;

    localparam int SYNC_W  = 6;
    localparam int PORCH_W = 8;

    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } lhtg_phase_e;

    function automatic lhtg_phase_e lhtg_next(input lhtg_phase_e p);
        case (p)
            PH_ACTIVE: return PH_FRONT;
            PH_FRONT:  return PH_SYNC;
            PH_SYNC:   return PH_BACK;
            default:   return PH_ACTIVE;
        endcase
    endfunction

    function automatic int lhtg_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lhtg_len_mux.sv
module lhtg_len_mux
    import lhtg_pkg::*;
#(
    parameter int PPL_W = 11,
    parameter int CNT_W = 11
) (
    input  lhtg_phase_e        phase_sel,
    input  logic [SYNC_W-1:0]  cfg_sync,
    input  logic [PORCH_W-1:0] cfg_front,
    input  logic [PORCH_W-1:0] cfg_back,
    input  logic [PPL_W-1:0]   cfg_ppl,
    output logic [CNT_W-1:0]   len
);
    always_comb begin
        case (phase_sel)
            PH_ACTIVE: len = CNT_W'(cfg_ppl);
            PH_FRONT:  len = CNT_W'(cfg_front);
            PH_SYNC:   len = CNT_W'(cfg_sync);
            default:   len = CNT_W'(cfg_back);
        endcase
    end
endmodule

// File: rtl/lhtg_phase_seq.sv
module lhtg_phase_seq
    import lhtg_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic [CNT_W-1:0] next_len,
    output lhtg_phase_e      phase_q,
    output logic             at_last
);
    logic [CNT_W-1:0] cnt_q;

    assign at_last = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_BACK;
            cnt_q   <= next_len;
        end else if (pix_en) begin
            if (at_last) begin
                phase_q <= lhtg_next(phase_q);
                cnt_q   <= next_len;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R12: disabled cycles freeze the sequencer
    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(phase_q) && $stable(cnt_q)));

    // R2: a phase change always goes to the successor phase
    assert_phase_order_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q != $past(phase_q)) |-> (phase_q == lhtg_next($past(phase_q))));

    // R11: within one phase the remaining length never grows
    assert_no_midphase_reload_R11: assert property (@(posedge clk) disable iff (rst)
        (phase_q == $past(phase_q)) |-> (cnt_q <= $past(cnt_q)));

    // R2: a phase is left only after an enabled final cycle
    assert_leave_on_last_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q != $past(phase_q)) |-> $past(pix_en && at_last));
endmodule

// File: rtl/lhtg_pin_stage.sv
module lhtg_pin_stage
    import lhtg_pkg::*;
(
    input  lhtg_phase_e phase_q,
    input  logic        at_last,
    input  logic        pix_en,
    input  logic        passive_mode,
    input  logic        sync_pol,
    output logic        line_sync,
    output logic        pix_valid,
    output logic        pix_clk_en,
    output logic        line_end
);
    logic in_sync;

    always_comb begin
        in_sync    = (phase_q == PH_SYNC);
        pix_valid  = (phase_q == PH_ACTIVE);
        line_sync  = in_sync ? sync_pol : ~sync_pol;
        pix_clk_en = pix_en & (~passive_mode | pix_valid);
        line_end   = pix_en & at_last & (phase_q == PH_BACK);
    end
endmodule

// File: rtl/lcd_hline_gen.sv
module lcd_hline_gen
    import lhtg_pkg::*;
#(
    parameter int PPL_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_en,
    input  logic               passive_mode,
    input  logic               sync_pol,
    input  logic [5:0]         cfg_sync,
    input  logic [7:0]         cfg_front,
    input  logic [7:0]         cfg_back,
    input  logic [PPL_W-1:0]   cfg_ppl,
    output logic               line_sync,
    output logic               pix_valid,
    output logic               pix_clk_en,
    output logic               line_end
);
    localparam int CNT_W = lhtg_max3(PPL_W, PORCH_W, SYNC_W);

    lhtg_phase_e      phase_q;
    lhtg_phase_e      load_sel;
    logic             at_last;
    logic [CNT_W-1:0] next_len;

    // reset parks in back porch; otherwise load the length of the successor
    assign load_sel = rst ? PH_BACK : lhtg_next(phase_q);

    lhtg_len_mux #(.PPL_W(PPL_W), .CNT_W(CNT_W)) u_len (
        .phase_sel (load_sel),
        .cfg_sync  (cfg_sync),
        .cfg_front (cfg_front),
        .cfg_back  (cfg_back),
        .cfg_ppl   (cfg_ppl),
        .len       (next_len)
    );

    lhtg_phase_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pix_en   (pix_en),
        .next_len (next_len),
        .phase_q  (phase_q),
        .at_last  (at_last)
    );

    lhtg_pin_stage u_pins (
        .phase_q      (phase_q),
        .at_last      (at_last),
        .pix_en       (pix_en),
        .passive_mode (passive_mode),
        .sync_pol     (sync_pol),
        .line_sync    (line_sync),
        .pix_valid    (pix_valid),
        .pix_clk_en   (pix_clk_en),
        .line_end     (line_end)
    );

    // R10: end of line hands over to the active phase
    assert_eol_to_active_R10: assert property (@(posedge clk) disable iff (rst)
        line_end |=> pix_valid);

    // R9: sync never asserted while pixels are valid
    assert_sync_idle_active_R9: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (line_sync != sync_pol));

    // R7: passive panels see no pixel clock outside the active phase
    assert_passive_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (passive_mode && !pix_valid) |-> !pix_clk_en);

    // R8: active panels see every enabled pixel clock
    assert_active_free_R8: assert property (@(posedge clk) disable iff (rst)
        !passive_mode |-> (pix_clk_en == pix_en));
endmodule

// File: tb/tb_lcd_hline_gen.sv
`timescale 1ns/1ps
module tb_lcd_hline_gen;
    localparam int PPL_W = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pix_en = 1'b0;
    logic             passive_mode = 1'b1;
    logic             sync_pol = 1'b1;
    logic [5:0]       cfg_sync = '0;
    logic [7:0]       cfg_front = '0;
    logic [7:0]       cfg_back = '0;
    logic [PPL_W-1:0] cfg_ppl = '0;
    logic             line_sync, pix_valid, pix_clk_en, line_end;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ph = 3;
    int exp_left = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lcd_hline_gen #(.PPL_W(PPL_W)) dut (
        .clk(clk), .rst(rst), .pix_en(pix_en), .passive_mode(passive_mode),
        .sync_pol(sync_pol), .cfg_sync(cfg_sync), .cfg_front(cfg_front),
        .cfg_back(cfg_back), .cfg_ppl(cfg_ppl), .line_sync(line_sync),
        .pix_valid(pix_valid), .pix_clk_en(pix_clk_en), .line_end(line_end)
    );

    function automatic int field_of(input int ph);
        case (ph)
            0: return int'(cfg_ppl);
            1: return int'(cfg_front);
            2: return int'(cfg_sync);
            default: return int'(cfg_back);
        endcase
    endfunction

    function automatic string tag_of(input int ph);
        case (ph)
            0: return "R6";
            1: return "R4";
            2: return "R3";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, expv);
        end
    endtask

    // outputs compared against the bench model, then model advances at the edge
    task automatic step();
        int e_valid, e_sync, e_clk, e_end;
        #1;
        e_valid = (exp_ph == 0);
        e_sync  = (exp_ph == 2) ? int'(sync_pol) : int'(!sync_pol);
        e_clk   = int'(pix_en && (!passive_mode || exp_ph == 0));
        e_end   = int'(pix_en && exp_ph == 3 && exp_left == 0);
        chk(pix_valid == e_valid, {"R2 R6 pix_valid in ", tag_of(exp_ph)}, int'(pix_valid), e_valid);
        chk(line_sync == e_sync, {"R9 line_sync in ", tag_of(exp_ph)}, int'(line_sync), e_sync);
        chk(pix_clk_en == e_clk, passive_mode ? "R7 pix_clk_en" : "R8 pix_clk_en",
            int'(pix_clk_en), e_clk);
        chk(line_end == e_end, "R10 line_end", int'(line_end), e_end);
        @(posedge clk);
        // R12: no enable, no progress
        if (pix_en) begin
            if (exp_left == 0) begin
                exp_ph   = (exp_ph + 1) % 4;
                exp_left = field_of(exp_ph);   // R11: captured only here
            end else begin
                exp_left--;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        cfg_back = 8'd5;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(pix_valid == 1'b0, "R1 pix_valid in reset", int'(pix_valid), 0);
        chk(line_sync == !sync_pol, "R1 line_sync in reset", int'(line_sync), int'(!sync_pol));
        @(negedge clk);
        rst = 1'b0;
        exp_ph = 3;
        exp_left = 5;   // R1: back porch of cfg_back+1 after release

        // directed: every field zero, four-cycle lines, passive panel
        pix_en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            if (i == 10) cfg_back = 8'd0;
            step();
        end

        // directed: largest sync and porches, active panel, low polarity
        passive_mode = 1'b0;
        sync_pol = 1'b0;
        cfg_sync = 6'd63;
        cfg_front = 8'd255;
        cfg_back = 8'd255;
        cfg_ppl = 11'd20;
        for (int i = 0; i < 1400; i++) step();

        // random: enable gaps (R12), mode/polarity flips, mid-phase rewrites (R11)
        for (int i = 0; i < 30000; i++) begin
            pix_en = ($urandom % 4) != 0;
            if (($urandom % 200) == 0) passive_mode = ~passive_mode;
            if (($urandom % 300) == 0) sync_pol = ~sync_pol;
            if (($urandom % 40) == 0) begin
                cfg_sync  = 6'($urandom % 8);
                cfg_front = 8'($urandom % 10);
                cfg_back  = 8'($urandom % 10);
                cfg_ppl   = PPL_W'($urandom % 24);
                if (($urandom % 10) == 0) cfg_ppl = '0;
            end
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule